// File: doc/BRIEF.md
# Integer ALU with Overflow Trap

This block is the combinational integer execute unit of a three-operand load/store RISC core. Each cycle it takes two 32-bit operands, a 5-bit constant shift count and a 5-bit operation code. From these it returns a 32-bit result and a flag that asks for an overflow exception. The instruction decoder sign-extends or zero-extends any immediate before it reaches the unit, so the unit only ever sees full-width operands. The register file and the logic that handles a raised flag both sit outside this block.

The unit covers five groups of operations:
- addition and subtraction, in trapping and non-trapping forms;
- the four bitwise functions;
- left, logical-right and arithmetic-right shifts, with the count taken either from the instruction field or from a register;
- signed and unsigned set-on-less-than;
- placing a constant in the upper half of the word.

One adder-subtractor serves both the arithmetic group and the compares. The compares reuse its difference, carry and overflow to form the less-than answer.

Top module: `intalu`

## Requirements
- R1: Codes 0 (add) and 2 (subtract, A minus B) return the 32-bit wrapped sum or difference. `ovf_trap` is 1 exactly when the two's-complement result overflows. The wrapped value is still returned when the flag is raised.
- R2: Codes 1 (add, no trap) and 3 (subtract, no trap) return the same wrapped value as codes 0 and 2, and `ovf_trap` stays 0 for them.
- R3: Codes 4, 5, 6 and 7 return A AND B, A OR B, A XOR B and NOT(A OR B) respectively.
- R4: Codes 8 (left), 9 (logical right) and 10 (arithmetic right) shift operand B by `shamt`. A logical right shift fills vacated bits with 0. An arithmetic right shift fills them with B[31].
- R5: Codes 11, 12 and 13 perform the same three shifts of B, with the count taken from A[4:0]. A[31:5] and `shamt` have no effect on these codes.
- R6: Code 14 returns 1 when A < B as two's-complement numbers and 0 otherwise. Code 15 does the same comparison with A and B taken as unsigned numbers. Bits 31:1 of the result are 0 for both codes.
- R7: Code 16 returns B[15:0] in result bits 31:16 and 0 in bits 15:0. Operand A has no effect on this code.
- R8: `ovf_trap` is 0 for every code other than 0 and 2. This includes compares whose internal subtraction overflows.
- R9: Codes 17 to 31 are unassigned. They return a result of 0 with `ovf_trap` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 32 | First operand; its low 5 bits give the count for register-count shifts |
| opnd_b | input | 32 | Second operand; the value that is shifted, and the source of the upper-half constant |
| shamt | input | 5 | Shift count from the instruction field |
| op | input | 5 | Operation code, encoded as given in the requirements |
| result | output | 32 | Operation result |
| ovf_trap | output | 1 | Requests an overflow exception for the trapping add and subtract |

## Verification
The shared adder is where two functions meet in the same evaluation. A set-on-less-than drives the adder into signed overflow, and that same overflow has to both correct the compare answer and be kept off the trap output. The tests provoke this by comparing the most negative and most positive values in both orders. They judge each such case on two points: the 0/1 result must be correct, and `ovf_trap` must be 0. The same operand pairs are then run through the trapping subtract, which must raise the flag, so both sides of the one overflow signal are checked.

// File: rtl/intalu_pkg.sv
package intalu_pkg;

    localparam int OP_W = 5;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 5'd0,
        OP_ADDU = 5'd1,
        OP_SUB  = 5'd2,
        OP_SUBU = 5'd3,
        OP_AND  = 5'd4,
        OP_OR   = 5'd5,
        OP_XOR  = 5'd6,
        OP_NOR  = 5'd7,
        OP_SLL  = 5'd8,
        OP_SRL  = 5'd9,
        OP_SRA  = 5'd10,
        OP_SLLV = 5'd11,
        OP_SRLV = 5'd12,
        OP_SRAV = 5'd13,
        OP_SLT  = 5'd14,
        OP_SLTU = 5'd15,
        OP_LUI  = 5'd16
    } alu_op_e;

    typedef enum logic [2:0] {
        GRP_ARITH,
        GRP_LOGIC,
        GRP_SHIFT,
        GRP_CMP,
        GRP_UPPER,
        GRP_NONE
    } alu_grp_e;

    typedef enum logic [1:0] {
        LF_AND,
        LF_OR,
        LF_XOR,
        LF_NOR
    } logic_fn_e;

    typedef enum logic [1:0] {
        SK_LEFT,
        SK_RLOG,
        SK_RARI
    } shift_kind_e;

    typedef struct packed {
        alu_grp_e    grp;
        logic        sub;
        logic        trap_en;
        logic        cmp_uns;
        logic_fn_e   lfn;
        shift_kind_e skind;
        logic        sh_var;
    } alu_ctl_t;

    function automatic alu_ctl_t decode_op(logic [OP_W-1:0] code);
        alu_ctl_t c;
        c.grp     = GRP_NONE;
        c.sub     = 1'b0;
        c.trap_en = 1'b0;
        c.cmp_uns = 1'b0;
        c.lfn     = LF_AND;
        c.skind   = SK_LEFT;
        c.sh_var  = 1'b0;
        case (code)
            OP_ADD:  begin c.grp = GRP_ARITH; c.trap_en = 1'b1; end
            OP_ADDU: begin c.grp = GRP_ARITH; end
            OP_SUB:  begin c.grp = GRP_ARITH; c.sub = 1'b1; c.trap_en = 1'b1; end
            OP_SUBU: begin c.grp = GRP_ARITH; c.sub = 1'b1; end
            OP_AND:  begin c.grp = GRP_LOGIC; c.lfn = LF_AND; end
            OP_OR:   begin c.grp = GRP_LOGIC; c.lfn = LF_OR;  end
            OP_XOR:  begin c.grp = GRP_LOGIC; c.lfn = LF_XOR; end
            OP_NOR:  begin c.grp = GRP_LOGIC; c.lfn = LF_NOR; end
            OP_SLL:  begin c.grp = GRP_SHIFT; c.skind = SK_LEFT; end
            OP_SRL:  begin c.grp = GRP_SHIFT; c.skind = SK_RLOG; end
            OP_SRA:  begin c.grp = GRP_SHIFT; c.skind = SK_RARI; end
            OP_SLLV: begin c.grp = GRP_SHIFT; c.skind = SK_LEFT; c.sh_var = 1'b1; end
            OP_SRLV: begin c.grp = GRP_SHIFT; c.skind = SK_RLOG; c.sh_var = 1'b1; end
            OP_SRAV: begin c.grp = GRP_SHIFT; c.skind = SK_RARI; c.sh_var = 1'b1; end
            OP_SLT:  begin c.grp = GRP_CMP; c.sub = 1'b1; end
            OP_SLTU: begin c.grp = GRP_CMP; c.sub = 1'b1; c.cmp_uns = 1'b1; end
            OP_LUI:  begin c.grp = GRP_UPPER; end
            default: c.grp = GRP_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/intalu_addsub.sv
module intalu_addsub #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             sub,
    output logic [WIDTH-1:0] sum,
    output logic             carry_out,
    output logic             ovf
);
    logic [WIDTH-1:0] b_eff;
    logic [WIDTH:0]   wide;

    always_comb begin
        b_eff     = b ^ {WIDTH{sub}};
        wide      = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub};
        sum       = wide[WIDTH-1:0];
        carry_out = wide[WIDTH];
        // operands of equal sign giving a result of the other sign
        ovf       = (a[WIDTH-1] == b_eff[WIDTH-1]) && (sum[WIDTH-1] != a[WIDTH-1]);
    end
endmodule

// File: rtl/intalu_cmp.sv
module intalu_cmp (
    input  logic diff_msb,
    input  logic diff_ovf,
    input  logic carry_out,
    input  logic unsigned_mode,
    output logic less
);
    // signed: sign of true difference; unsigned: a borrow occurred
    always_comb begin
        if (unsigned_mode) less = ~carry_out;
        else               less = diff_msb ^ diff_ovf;
    end
endmodule

// File: rtl/intalu_logic.sv
module intalu_logic #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0]       a,
    input  logic [WIDTH-1:0]       b,
    input  intalu_pkg::logic_fn_e  fn,
    output logic [WIDTH-1:0]       y
);
    import intalu_pkg::*;
    always_comb begin
        case (fn)
            LF_AND:  y = a & b;
            LF_OR:   y = a | b;
            LF_XOR:  y = a ^ b;
            default: y = ~(a | b);
        endcase
    end
endmodule

// File: rtl/intalu_shift.sv
module intalu_shift #(
    parameter int WIDTH = 32,
    localparam int SHW  = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0]         val,
    input  logic [SHW-1:0]           amt,
    input  intalu_pkg::shift_kind_e  kind,
    output logic [WIDTH-1:0]         y
);
    import intalu_pkg::*;

    logic             left;
    logic             fill;
    logic [WIDTH-1:0] src;
    logic [WIDTH-1:0] stage [SHW+1];

    always_comb begin
        left = (kind == SK_LEFT);
        fill = (kind == SK_RARI) ? val[WIDTH-1] : 1'b0;
        for (int i = 0; i < WIDTH; i++) begin
            src[i] = left ? val[WIDTH-1-i] : val[i];
        end
    end

    assign stage[0] = src;

    // log2 barrel: one right-shift stage per count bit
    for (genvar s = 0; s < SHW; s++) begin : g_stage
        localparam int STEP = 1 << s;
        assign stage[s+1] = amt[s] ? {{STEP{fill}}, stage[s][WIDTH-1:STEP]} : stage[s];
    end

    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            y[i] = left ? stage[SHW][WIDTH-1-i] : stage[SHW][i];
        end
    end
endmodule

// File: rtl/intalu.sv
module intalu #(
    parameter int WIDTH = 32,
    localparam int SHW  = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic [SHW-1:0]   shamt,
    input  logic [4:0]       op,
    output logic [WIDTH-1:0] result,
    output logic             ovf_trap
);
    import intalu_pkg::*;

    localparam int HALF = WIDTH / 2;

    alu_ctl_t         ctl;
    logic [WIDTH-1:0] as_sum;
    logic             as_cout;
    logic             as_ovf;
    logic             lt;
    logic [WIDTH-1:0] lg_y;
    logic [WIDTH-1:0] sh_y;
    logic [SHW-1:0]   sh_amt;

    assign ctl    = decode_op(op);
    assign sh_amt = ctl.sh_var ? opnd_a[SHW-1:0] : shamt;

    intalu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a(opnd_a), .b(opnd_b), .sub(ctl.sub),
        .sum(as_sum), .carry_out(as_cout), .ovf(as_ovf)
    );

    intalu_cmp u_cmp (
        .diff_msb(as_sum[WIDTH-1]), .diff_ovf(as_ovf),
        .carry_out(as_cout), .unsigned_mode(ctl.cmp_uns), .less(lt)
    );

    intalu_logic #(.WIDTH(WIDTH)) u_logic (
        .a(opnd_a), .b(opnd_b), .fn(ctl.lfn), .y(lg_y)
    );

    intalu_shift #(.WIDTH(WIDTH)) u_shift (
        .val(opnd_b), .amt(sh_amt), .kind(ctl.skind), .y(sh_y)
    );

    always_comb begin
        case (ctl.grp)
            GRP_ARITH: result = as_sum;
            GRP_LOGIC: result = lg_y;
            GRP_SHIFT: result = sh_y;
            GRP_CMP:   result = {{(WIDTH-1){1'b0}}, lt};
            GRP_UPPER: result = {opnd_b[HALF-1:0], {HALF{1'b0}}};
            default:   result = '0;
        endcase
        ovf_trap = ctl.trap_en & as_ovf;
    end
endmodule

// File: rtl/intalu_chk.sv
module intalu_chk #(
    parameter int WIDTH = 32,
    localparam int SHW  = $clog2(WIDTH)
) (
    input logic [WIDTH-1:0] opnd_a,
    input logic [WIDTH-1:0] opnd_b,
    input logic [SHW-1:0]   shamt,
    input logic [4:0]       op,
    input logic [WIDTH-1:0] result,
    input logic             ovf_trap
);
    localparam int HALF = WIDTH / 2;

    always_comb begin
        // R2
        no_overflow_unsigned_chk: assert (!((op == 5'd1 || op == 5'd3) && ovf_trap))
            else $error("unsigned add/sub raised trap");
        // R8
        trap_scope_chk: assert (!ovf_trap || op == 5'd0 || op == 5'd2)
            else $error("trap raised by non-trapping code %0d", op);
        // R1
        add_wrap_chk: assert (!(op == 5'd0) || result == opnd_a + opnd_b)
            else $error("add result not the wrapped sum");
        // R6
        cmp_onebit_chk: assert (!(op == 5'd14 || op == 5'd15) || result[WIDTH-1:1] == '0)
            else $error("compare result wider than one bit");
        // R7
        upper_low_zero_chk: assert (!(op == 5'd16) || result[HALF-1:0] == '0)
            else $error("upper-constant low half not zero");
        // R3
        nor_chk: assert (!(op == 5'd7) || result == ~(opnd_a | opnd_b))
            else $error("nor mismatch");
        // R9
        unused_code_chk: assert (op < 5'd17 || (result == '0 && !ovf_trap))
            else $error("unassigned code produced output");
    end
endmodule

bind intalu intalu_chk #(.WIDTH(WIDTH)) u_chk (
    .opnd_a(opnd_a), .opnd_b(opnd_b), .shamt(shamt), .op(op),
    .result(result), .ovf_trap(ovf_trap)
);

// File: tb/intalu_test.sv
module intalu_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] a, b;
    logic [4:0]  sh;
    logic [4:0]  op;
    logic [31:0] result;
    logic        ovf_trap;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done  = 1'b0;

    always #2 clk = ~clk;

    intalu uut (
        .opnd_a(a), .opnd_b(b), .shamt(sh), .op(op),
        .result(result), .ovf_trap(ovf_trap)
    );

    task automatic check(string tag, logic [4:0] c, logic [31:0] av, logic [31:0] bv,
                         logic [4:0] s, logic [31:0] exp_r, logic exp_t);
        @(negedge clk);
        op = c; a = av; b = bv; sh = s;
        #1;
        n_chk++;
        if (result !== exp_r || ovf_trap !== exp_t) begin
            n_bad++;
            $display("FAIL %s op=%0d a=%h b=%h sh=%0d: got res=%h trap=%b, want res=%h trap=%b",
                     tag, c, av, bv, s, result, ovf_trap, exp_r, exp_t);
        end
    endtask

    function automatic logic add_ovf(logic [31:0] x, logic [31:0] y);
        logic [32:0] w = {x[31], x} + {y[31], y};
        return w[32] != w[31];
    endfunction

    function automatic logic sub_ovf(logic [31:0] x, logic [31:0] y);
        logic [32:0] w = {x[31], x} - {y[31], y};
        return w[32] != w[31];
    endfunction

    task automatic t_idle;
        check("R1 idle", 5'd0, 32'h0, 32'h0, 5'd0, 32'h0, 1'b0);
    endtask

    task automatic t_trap_arith;
        check("R1 add", 5'd0, 32'd7, 32'd5, 0, 32'd12, 1'b0);
        check("R1 add pos ovf", 5'd0, 32'h7fff_ffff, 32'd1, 0, 32'h8000_0000, 1'b1);
        check("R1 add neg ovf", 5'd0, 32'h8000_0000, 32'hffff_ffff, 0, 32'h7fff_ffff, 1'b1);
        check("R1 add mixed sign", 5'd0, 32'h8000_0000, 32'h7fff_ffff, 0, 32'hffff_ffff, 1'b0);
        check("R1 sub", 5'd2, 32'd3, 32'd10, 0, 32'hffff_fff9, 1'b0);
        check("R1 sub ovf", 5'd2, 32'h8000_0000, 32'd1, 0, 32'h7fff_ffff, 1'b1);
        check("R1 sub ovf2", 5'd2, 32'h7fff_ffff, 32'hffff_ffff, 0, 32'h8000_0000, 1'b1);
        for (int i = 0; i < 40; i++) begin
            logic [31:0] x = 32'h9e37_79b9 * (i + 1);
            logic [31:0] y = 32'h7f4a_7c15 * (i + 3);
            check("R1 sweep add", 5'd0, x, y, 0, x + y, add_ovf(x, y));
            check("R1 sweep sub", 5'd2, x, y, 0, x - y, sub_ovf(x, y));
        end
    endtask

    task automatic t_no_trap;
        check("R2 addu wrap", 5'd1, 32'h7fff_ffff, 32'd1, 0, 32'h8000_0000, 1'b0);
        check("R2 subu wrap", 5'd3, 32'h8000_0000, 32'd1, 0, 32'h7fff_ffff, 1'b0);
        check("R2 addu carry", 5'd1, 32'hffff_ffff, 32'd2, 0, 32'd1, 1'b0);
    endtask

    task automatic t_bitwise;
        logic [31:0] x = 32'hf0f0_1234;
        logic [31:0] y = 32'h0ff0_a5a5;
        check("R3 and", 5'd4, x, y, 0, x & y, 1'b0);
        check("R3 or",  5'd5, x, y, 0, x | y, 1'b0);
        check("R3 xor", 5'd6, x, y, 0, x ^ y, 1'b0);
        check("R3 nor", 5'd7, x, y, 0, ~(x | y), 1'b0);
        check("R3 nor zeros", 5'd7, 32'h0, 32'h0, 0, 32'hffff_ffff, 1'b0);
    endtask

    task automatic t_const_shift;
        logic [31:0] v = 32'h8765_4321;
        check("R4 sll 4",  5'd8,  32'h0, v, 5'd4,  32'h7654_3210, 1'b0);
        check("R4 srl 4",  5'd9,  32'h0, v, 5'd4,  32'h0876_5432, 1'b0);
        check("R4 sra 4",  5'd10, 32'h0, v, 5'd4,  32'hf876_5432, 1'b0);
        check("R4 sra pos",5'd10, 32'h0, 32'h4000_0000, 5'd30, 32'd1, 1'b0);
        check("R4 sra 31", 5'd10, 32'h0, v, 5'd31, 32'hffff_ffff, 1'b0);
        check("R4 srl 31", 5'd9,  32'h0, v, 5'd31, 32'd1, 1'b0);
        check("R4 sll 0",  5'd8,  32'h0, v, 5'd0,  v, 1'b0);
        for (int s = 0; s < 32; s++) begin
            check("R4 sra sweep", 5'd10, 32'h0, v, 5'(s), 32'($signed(v) >>> s), 1'b0);
            check("R4 sll sweep", 5'd8,  32'h0, v, 5'(s), v << s, 1'b0);
        end
    endtask

    task automatic t_var_shift;
        logic [31:0] v = 32'h8765_4321;
        // A upper bits set and shamt nonzero: must not change the count
        check("R5 sllv", 5'd11, 32'hffff_ffe8, v, 5'd3, v << 8, 1'b0);
        check("R5 srlv", 5'd12, 32'h1234_5608, v, 5'd1, v >> 8, 1'b0);
        check("R5 srav", 5'd13, 32'hdead_be08, v, 5'd17, 32'hff87_6543, 1'b0);
        check("R5 srav zero", 5'd13, 32'hffff_ffe0, v, 5'd9, v, 1'b0);
    endtask

    task automatic t_compare;
        check("R6 slt neg<pos", 5'd14, 32'hffff_ffff, 32'd1, 0, 32'd1, 1'b0);
        check("R6 sltu neg<pos", 5'd15, 32'hffff_ffff, 32'd1, 0, 32'd0, 1'b0);
        check("R6 slt equal", 5'd14, 32'd9, 32'd9, 0, 32'd0, 1'b0);
        check("R6 sltu small", 5'd15, 32'd2, 32'h8000_0000, 0, 32'd1, 1'b0);
        // subtraction inside compare overflows here
        check("R6 slt min<max", 5'd14, 32'h8000_0000, 32'h7fff_ffff, 0, 32'd1, 1'b0);
        check("R6 slt max<min", 5'd14, 32'h7fff_ffff, 32'h8000_0000, 0, 32'd0, 1'b0);
    endtask

    task automatic t_upper;
        check("R7 lui", 5'd16, 32'hffff_ffff, 32'habcd_1234, 0, 32'h1234_0000, 1'b0);
        check("R7 lui a0", 5'd16, 32'h0, 32'h0000_8001, 0, 32'h8001_0000, 1'b0);
    endtask

    task automatic t_trap_scope;
        check("R8 sltu overflow pair", 5'd15, 32'h8000_0000, 32'h7fff_ffff, 0, 32'd0, 1'b0);
        check("R8 nor ovf pair", 5'd7, 32'h7fff_ffff, 32'd1, 0, 32'h8000_0000, 1'b0);
        check("R8 sub same pair", 5'd2, 32'h8000_0000, 32'h7fff_ffff, 0, 32'h0000_0001, 1'b1);
    endtask

    task automatic t_unused;
        for (int c = 17; c < 32; c++) begin
            check("R9 unassigned", 5'(c), 32'h7fff_ffff, 32'h7fff_ffff, 5'd3, 32'h0, 1'b0);
        end
    endtask

    initial begin
        a = '0; b = '0; sh = '0; op = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        t_idle();
        t_trap_arith();
        t_no_trap();
        t_bitwise();
        t_const_shift();
        t_var_shift();
        t_compare();
        t_upper();
        t_trap_scope();
        t_unused();
        done = 1'b1;
    end

    initial begin
        for (int cyc = 0; cyc < 100000; cyc++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, got done=0 want done=1");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule